// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the operating mode of a small processor system and decides when it moves between four modes: normal run, sleep, software standby and hardware standby. The CPU asks for a low-power mode with a one-cycle sleep strobe. A standby-select bit picks sleep or software standby. A dedicated active-low standby pin forces hardware standby from any mode. The wake events are a non-maskable interrupt line, a maskable interrupt request, a DMA address-error flag, and power-on and manual reset strobes. Each mode accepts its own set of these events.

From the registered mode the block derives several control outputs: enables for the CPU clock and the peripheral clock, a RAM-retain indication, a pin high-impedance control and a pin-initialise control. It also drives an internal reset request that lasts one cycle, plus a two-bit mode code. Generating clocks, timing oscillator settling and switching power rails are left to other logic. The non-maskable interrupt line is asynchronous, so it passes through a synchronizer chain before its rising edge is detected.

Top module: `lpm_ctrl`

## Requirements
- R1: While `stby_pin_n` is 0 at a clock edge, `mode` is 3 (hardware standby) after that edge. This holds from every mode and takes priority over every other input, including `por` and `sleep_req`.
- R2: In run mode (0), `sleep_req`=1 with `stby_sel`=1 moves the block to software standby (`mode`=2). There `cpu_clk_en` and `per_clk_en` are both 0.
- R3: In run mode, `sleep_req`=1 with `stby_sel`=0 moves the block to sleep (`mode`=1). There `cpu_clk_en`=0 and `per_clk_en`=1.
- R4: Sleep returns to run when any of `irq`, `dma_err`, `mrst` or `por` is 1. A reset pulse is issued only when the cause is `mrst` or `por`. The `nmi` input has no effect in sleep.
- R5: Software standby is left only on a rising edge of `nmi` or on `por`. The `nmi` edge takes effect at the third clock edge after `nmi` goes high, because of the two-flop synchronizer and the edge register. `irq`, `dma_err`, `mrst` and `sleep_req` are ignored in software standby.
- R6: Every exit from software standby to run sets `int_rst_req` to 1 for exactly the first cycle in run.
- R7: Hardware standby is left, to run with a reset pulse, only when `stby_pin_n`=1 and `por`=1 at the same edge. A high pin alone keeps `mode` at 3.
- R8: `pin_hiz` is 1 only in software standby. `pin_init` is 1 only in hardware standby. Both are 0 in run and sleep.
- R9: `ram_retain` is 1 in software standby. In hardware standby it equals the inverse of `ram_en` sampled at the edge that entered hardware standby. It is 0 in run and sleep.
- R10: A one-cycle `por` beats every wake or sleep event in the same cycle (but not a low `stby_pin_n`). The block is then in run, and `int_rst_req` is 1 for exactly one cycle.
- R11: Mode codes are run=0, sleep=1, software standby=2, hardware standby=3. Each code appears after the edge that samples its cause. After `rst_n` the block is in run with both clock enables at 1 and every other output at 0.
- R12: In run, `mrst` or `por` keeps the block in run and pulses `int_rst_req`. This beats `sleep_req`. `irq`, `dma_err` and `nmi` have no effect in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller flops |
| sleep_req | input | 1 | One-cycle strobe from the CPU asking for a low-power mode |
| stby_sel | input | 1 | 1 selects software standby, 0 selects sleep |
| stby_pin_n | input | 1 | Hardware standby pin, active low |
| nmi | input | 1 | Asynchronous non-maskable interrupt line |
| irq | input | 1 | Maskable interrupt request |
| dma_err | input | 1 | DMA address-error flag |
| por | input | 1 | Power-on reset strobe |
| mrst | input | 1 | Manual reset strobe |
| ram_en | input | 1 | Software RAM-enable bit; must be 0 before hardware standby for retention |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| ram_retain | output | 1 | RAM contents are retained |
| int_rst_req | output | 1 | One-cycle internal reset request |
| pin_hiz | output | 1 | Put the pins in high impedance |
| pin_init | output | 1 | Drive the pins to their initialised state |
| mode | output | 2 | Current mode code |

## Verification
A wrong mode register shows up at once on the ports, in the cycle after the faulty edge, because `mode`, both clock enables and both pin controls are decoded straight from it. A reset pulse that is lost or doubled shows on `int_rst_req` in the first cycle in run. A fault in the synchronizer shows as a software-standby exit that comes one cycle too early or too late against the three-edge latency. The bench steps through every mode and every combination of wake and sleep inputs, and compares the next mode, the reset pulse and every decoded output with a model built from the requirements.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        M_RUN   = 2'd0,
        M_SLEEP = 2'd1,
        M_SSTBY = 2'd2,
        M_HSTBY = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  rst;
        logic  ret;
    } ctl_state_t;

endpackage

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise = s_q.chain[LAST] & ~s_q.prev;

    // R5: an edge indication never lasts two cycles
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_req,
    input  logic  stby_sel,
    input  logic  stby_pin_n,
    input  logic  nmi_rise,
    input  logic  irq,
    input  logic  dma_err,
    input  logic  por,
    input  logic  mrst,
    input  logic  ram_en,
    output mode_e mode_q,
    output logic  rst_q,
    output logic  ret_q
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        if (!stby_pin_n) begin
            st_d.mode = M_HSTBY;
            if (st_q.mode != M_HSTBY) begin
                st_d.ret = ~ram_en;
            end
        end else begin
            unique case (st_q.mode)
                M_RUN: begin
                    if (por || mrst) begin
                        st_d.rst = 1'b1;
                    end else if (sleep_req) begin
                        st_d.mode = stby_sel ? M_SSTBY : M_SLEEP;
                    end
                end
                M_SLEEP: begin
                    if (por || mrst) begin
                        st_d.mode = M_RUN;
                        st_d.rst  = 1'b1;
                    end else if (irq || dma_err) begin
                        st_d.mode = M_RUN;
                    end
                end
                M_SSTBY: begin
                    if (por || nmi_rise) begin
                        st_d.mode = M_RUN;
                        st_d.rst  = 1'b1;
                    end
                end
                M_HSTBY: begin
                    if (por) begin
                        st_d.mode = M_RUN;
                        st_d.rst  = 1'b1;
                    end
                end
                default: st_d.mode = M_RUN;
            endcase
            if (st_d.mode != M_HSTBY) begin
                st_d.ret = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_RUN, rst: 1'b0, ret: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign rst_q  = st_q.rst;
    assign ret_q  = st_q.ret;

    // R1: the standby pin overrides everything
    p_pin_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_pin_n |=> mode_q == M_HSTBY);

    // R5: software standby holds without a qualifying wake
    p_sstby_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SSTBY && stby_pin_n && !por && !nmi_rise) |=> mode_q == M_SSTBY);

    // R6: leaving software standby for run always carries a reset
    p_sstby_exit_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SSTBY && stby_pin_n) |=> (mode_q == M_SSTBY || rst_q));

    // R7: hardware standby needs both pin high and power-on reset
    p_hstby_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HSTBY && !(stby_pin_n && por)) |=> mode_q == M_HSTBY);

    // R9: retention flag captured from the RAM enable on entry
    p_ret_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_pin_n && mode_q != M_HSTBY) |=> ret_q == !$past(ram_en));

    // R10: power-on reset outside hardware standby lands in run with a pulse
    p_por_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (por && stby_pin_n) |=> (mode_q == M_RUN && rst_q));

endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
    import lpm_pkg::*;
(
    input  mode_e             mode_q,
    input  logic              rst_q,
    input  logic              ret_q,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              ram_retain,
    output logic              int_rst_req,
    output logic              pin_hiz,
    output logic              pin_init,
    output logic [MODE_W-1:0] mode
);

    always_comb begin
        cpu_clk_en  = (mode_q == M_RUN);
        per_clk_en  = (mode_q == M_RUN) || (mode_q == M_SLEEP);
        ram_retain  = (mode_q == M_SSTBY) || ((mode_q == M_HSTBY) && ret_q);
        int_rst_req = rst_q;
        pin_hiz     = (mode_q == M_SSTBY);
        pin_init    = (mode_q == M_HSTBY);
        mode        = mode_q;
    end

    // R8: the two pin controls are never active together
    always_comb begin
        a_pins_excl_r8: assert ($onehot0({pin_hiz, pin_init}));
        a_clk_order_r2: assert (!cpu_clk_en || per_clk_en);
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NMI_SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       stby_sel,
    input  logic       stby_pin_n,
    input  logic       nmi,
    input  logic       irq,
    input  logic       dma_err,
    input  logic       por,
    input  logic       mrst,
    input  logic       ram_en,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       ram_retain,
    output logic       int_rst_req,
    output logic       pin_hiz,
    output logic       pin_init,
    output logic [1:0] mode
);

    logic  nmi_rise;
    mode_e mode_q;
    logic  rst_q;
    logic  ret_q;

    lpm_edge_sync #(.STAGES(NMI_SYNC_STAGES)) u_nmi_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi),
        .rise     (nmi_rise)
    );

    lpm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .stby_sel   (stby_sel),
        .stby_pin_n (stby_pin_n),
        .nmi_rise   (nmi_rise),
        .irq        (irq),
        .dma_err    (dma_err),
        .por        (por),
        .mrst       (mrst),
        .ram_en     (ram_en),
        .mode_q     (mode_q),
        .rst_q      (rst_q),
        .ret_q      (ret_q)
    );

    lpm_out_dec u_dec (
        .mode_q      (mode_q),
        .rst_q       (rst_q),
        .ret_q       (ret_q),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .ram_retain  (ram_retain),
        .int_rst_req (int_rst_req),
        .pin_hiz     (pin_hiz),
        .pin_init    (pin_init),
        .mode        (mode)
    );

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, stby_sel = 0, stby_pin_n = 1, nmi = 0;
    logic irq = 0, dma_err = 0, por = 0, mrst = 0, ram_en = 1;
    logic cpu_clk_en, per_clk_en, ram_retain, int_rst_req, pin_hiz, pin_init;
    logic [1:0] mode;

    int checks = 0;
    int failures = 0;
    logic exp_ret_h = 1'b0;

    always #2.5 clk = ~clk;

    lpm_ctrl u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
        .stby_pin_n(stby_pin_n), .nmi(nmi), .irq(irq), .dma_err(dma_err),
        .por(por), .mrst(mrst), .ram_en(ram_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .ram_retain(ram_retain), .int_rst_req(int_rst_req),
        .pin_hiz(pin_hiz), .pin_init(pin_init), .mode(mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        sleep_req = 0; irq = 0; dma_err = 0; por = 0; mrst = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
        clear_in();
    endtask

    // decoded outputs for a given mode (R2 R3 R8 R9 R11)
    task automatic chk_outs(input string req, input int m);
        chk(req, "mode", int'(mode), m);
        chk("R2", "cpu_clk_en", int'(cpu_clk_en), (m == 0) ? 1 : 0);
        chk("R3", "per_clk_en", int'(per_clk_en), (m <= 1) ? 1 : 0);
        chk("R8", "pin_hiz", int'(pin_hiz), (m == 2) ? 1 : 0);
        chk("R8", "pin_init", int'(pin_init), (m == 3) ? 1 : 0);
        chk("R9", "ram_retain", int'(ram_retain),
            (m == 2) ? 1 : ((m == 3) ? int'(exp_ret_h) : 0));
    endtask

    task automatic go_run();
        stby_pin_n = 1; por = 1;
        step();
        step();
    endtask

    task automatic go_state(input int s, input logic ren);
        go_run();
        if (s == 1) begin
            sleep_req = 1; stby_sel = 0; step();
        end else if (s == 2) begin
            sleep_req = 1; stby_sel = 1; step();
        end else if (s == 3) begin
            ram_en = ren; exp_ret_h = ~ren; stby_pin_n = 0; step();
            ram_en = 1;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        #1;
        // R11 reset state
        chk_outs("R11", 0);
        chk("R11", "int_rst_req", int'(int_rst_req), 0);
        rst_n = 1;
        @(negedge clk);

        // Sweep: every start mode x every combination of sleep/wake inputs
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 64; c++) begin
                int em;
                int er;
                logic ci, cd, cm, cp, cs, css;
                ci = c[0]; cd = c[1]; cm = c[2]; cp = c[3]; cs = c[4]; css = c[5];
                go_state(s, c[1]);
                chk_outs("R11", s);
                // model from the requirements
                em = s; er = 0;
                case (s)
                    0: if (cp || cm) er = 1;                          // R12 R10
                       else if (cs) em = css ? 2 : 1;                  // R2 R3
                    1: if (cp || cm) begin em = 0; er = 1; end         // R4
                       else if (ci || cd) em = 0;
                    2: if (cp) begin em = 0; er = 1; end               // R5 R6
                    default: if (cp) begin em = 0; er = 1; end         // R7
                endcase
                stby_pin_n = 1;
                irq = ci; dma_err = cd; mrst = cm; por = cp; sleep_req = cs; stby_sel = css;
                step();
                chk_outs((s == 3) ? "R7" : ((s == 2) ? "R5" : "R4"), em);
                chk("R10", "int_rst_req", int'(int_rst_req), er);
                step();
                chk("R10", "int_rst_req one cycle", int'(int_rst_req), 0);
            end
        end

        // R1: low pin beats por and sleep from each mode
        for (int s = 0; s < 3; s++) begin
            go_state(s, 1'b1);
            stby_pin_n = 0; por = 1; sleep_req = 1; mrst = 1; ram_en = 0; exp_ret_h = 1;
            step();
            ram_en = 1;
            chk_outs("R1", 3);
            chk("R1", "int_rst_req", int'(int_rst_req), 0);
        end
        stby_pin_n = 1;

        // R5 R6: NMI edge leaves software standby after three edges
        go_state(2, 1'b1);
        nmi = 1;
        step();
        chk("R5", "mode after 1 edge", int'(mode), 2);
        step();
        chk("R5", "mode after 2 edges", int'(mode), 2);
        step();
        chk("R5", "mode after 3 edges", int'(mode), 0);
        chk("R6", "int_rst_req on nmi exit", int'(int_rst_req), 1);
        step();
        chk("R6", "int_rst_req drops", int'(int_rst_req), 0);

        // R5: NMI already high on entry gives no edge
        sleep_req = 1; stby_sel = 1;
        step();
        repeat (4) step();
        chk("R5", "level nmi no exit", int'(mode), 2);
        nmi = 0;
        repeat (4) step();
        chk("R5", "falling nmi no exit", int'(mode), 2);

        // R4: NMI ignored in sleep; R12: ignored in run
        go_state(1, 1'b1);
        nmi = 1;
        repeat (4) step();
        chk("R4", "nmi in sleep", int'(mode), 1);
        nmi = 0;
        repeat (3) step();
        go_run();
        nmi = 1;
        repeat (4) step();
        chk("R12", "nmi in run mode", int'(mode), 0);
        chk("R12", "nmi in run rst", int'(int_rst_req), 0);
        nmi = 0;
        repeat (3) step();

        // R7: pin high alone held for several cycles keeps hardware standby
        go_state(3, 1'b1);
        stby_pin_n = 1;
        repeat (5) step();
        chk_outs("R7", 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule